// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block is the configuration register file of a PC-class chipset, reached over a byte-wide I/O bus through two ports. The first port holds an 8-bit pointer, and the second port reads or writes the register that the pointer selects. Sixteen registers sit at pointer values 0x60 to 0x6F. Each register applies its own mask of writable bits. Bits outside the mask keep their value. Two revision fields are hardwired and read back fixed values whatever is written.

All sixteen registers leave the block as one flat vector, so timing, shadow and bank logic elsewhere can use them. The block also decodes the fields that an expanded-memory page mapper needs: the mapper enable, its I/O port base, the page frame base, a 2 MB region and start address for each of the four pages, the total paged memory size and its page count. A one-cycle update strobe follows every write to a register that feeds the mapper, so the mapper knows to re-evaluate.

Top module: `cfg_idx_port`

## Requirements
- R1: A write to I/O address 0x22 loads all 8 bits of the pointer. A read of 0x22 returns the pointer, which is 0x00 after reset.
- R2: A read of 0x23 returns the register the pointer selects. Writes to any address other than 0x22 and 0x23 change nothing, and reads of any other address, or reads made without the read strobe, return 0xFF.
- R3: A write to 0x23 changes only the bits in the selected register's writable mask. The masks are: 0x60→0x34, 0x62→0x3F, 0x66→0x80, 0x6A→0xE0, 0x6C→0xF0, 0x6F→0xE6, 0x63→0x00, 0x64→0x00. Registers 0x61, 0x65, 0x67, 0x68, 0x69, 0x6B, 0x6D and 0x6E are fully writable.
- R4: Register 0x60 bits 7:6 and register 0x64 bits 6:5 always read as binary 10, whatever is written.
- R5: Register 0x6B drives the following outputs: bit 4 drives `ems_en`, bit 6 drives `uma_reloc`, bits 3:2 drive `ems_ws` and bits 1:0 drive `rom_ws`.
- R6: Register 0x6F bits 7:5 give the paged memory size, which is 512 KB for code 0 and code×1024 KB for codes 1 to 7. `ems_pages` equals that size divided by 16.
- R7: `ems_io_base` = 0x208 + 0x10×(0x6D bits 3:0). `ems_frame_base` = 0xC0000 + 0x4000×(0x6D bits 7:4).
- R8: The 2-bit region of page p is register 0x6E bits (7−2p):(6−2p). It appears at `ems_page_ext[2p+1:2p]`. The page start `ems_page_start[24p+23:24p]` equals that region × 0x200000.
- R9: A write to 0x23 while the pointer is outside 0x60–0x6F changes no register, and a read of 0x23 there returns 0xFF.
- R10: `cfg_update` is high for exactly the one cycle after each write to 0x23 that targets 0x6B, 0x6D, 0x6E or 0x6F, and low otherwise.
- R11: After reset, every register reads 0x00 except 0x60, which reads 0x80, and 0x64, which reads 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| cfg_flat | output | 8×NREG | All registers, register 0x60+i at bits [8i+7:8i] |
| ems_en | output | 1 | Page mapper enable |
| uma_reloc | output | 1 | Upper memory relocate enable |
| ems_ws | output | 2 | Mapped access wait states |
| rom_ws | output | 2 | ROM access wait states |
| ems_io_base | output | 16 | Mapper I/O port base |
| ems_frame_base | output | 20 | Page frame base address |
| ems_page_ext | output | 8 | 2 MB region of each page |
| ems_page_start | output | 96 | Start address of each page's region |
| ems_size_kb | output | 13 | Paged memory size in KB |
| ems_pages | output | 9 | Number of 16 KB pages |
| cfg_update | output | 1 | One-cycle strobe after a mapper-relevant write |

## Verification
The case hardest to reach from the ports is a data write while the pointer is outside the register window, or just past either edge of it (0x5F, 0x70). The pointer can only be moved by a separate index write, and the effect of a stray data write can only be seen through later reads. The random stimulus therefore draws pointer values from a span that straddles both edges of the window. After every access, the whole flat register vector and all the derived outputs are compared with a model. A directed pass also writes to an unrelated address and makes a strobe-less read.

// File: rtl/cfg_idx_port.sv
module cfg_idx_port #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 'h22,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h23,
  parameter logic [7:0] BASE = 8'h60,
  parameter int NREG = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  output logic [8*NREG-1:0]   cfg_flat,
  output logic                ems_en,
  output logic                uma_reloc,
  output logic [1:0]          ems_ws,
  output logic [1:0]          rom_ws,
  output logic [15:0]         ems_io_base,
  output logic [19:0]         ems_frame_base,
  output logic [7:0]          ems_page_ext,
  output logic [95:0]         ems_page_start,
  output logic [12:0]         ems_size_kb,
  output logic [8:0]          ems_pages,
  output logic                cfg_update
);
  localparam int OFS_W = $clog2(NREG);
  localparam int O_MEMCFG = 11;
  localparam int O_MAPBASE = 13;
  localparam int O_PGEXT = 14;
  localparam int O_MISC = 15;

  function automatic logic [7:0] wmask(int i);
    case (i)
      0: return 8'h34;
      1: return 8'hFF;
      2: return 8'h3F;
      5, 7, 8, 9, 11, 13, 14: return 8'hFF;
      6: return 8'h80;
      10: return 8'hE0;
      12: return 8'hF0;
      15: return 8'hE6;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fixv(int i);
    case (i)
      0: return 8'h80;
      4: return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] idx_q;
  logic [7:0] regs_q [NREG];
  logic [7:0] diff;
  logic [OFS_W-1:0] ofs;
  logic in_range, dat_wr, hit_map;

  assign diff = idx_q - BASE;
  assign ofs = diff[OFS_W-1:0];
  assign in_range = diff < 8'(NREG);
  assign dat_wr = io_wr && io_addr == DAT_PORT && in_range;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idx_q <= 8'h00;
    else if (io_wr && io_addr == IDX_PORT) idx_q <= io_wdata;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] M = wmask(g);
    localparam logic [7:0] F = fixv(g);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) regs_q[g] <= F;
      else if (dat_wr && ofs == OFS_W'(g))
        regs_q[g] <= (regs_q[g] & ~M) | (io_wdata & M) | F;
    assign cfg_flat[8*g +: 8] = regs_q[g];
  end

  assign hit_map = dat_wr && (ofs == OFS_W'(O_MEMCFG) || ofs == OFS_W'(O_MAPBASE) ||
                              ofs == OFS_W'(O_PGEXT) || ofs == OFS_W'(O_MISC));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_update <= 1'b0;
    else cfg_update <= hit_map;

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd) begin
      if (io_addr == IDX_PORT) io_rdata = idx_q;
      else if (io_addr == DAT_PORT && in_range) io_rdata = regs_q[ofs];
    end
  end

  logic [2:0] size_code;
  assign size_code = regs_q[O_MISC][7:5];

  assign ems_en = regs_q[O_MEMCFG][4];
  assign uma_reloc = regs_q[O_MEMCFG][6];
  assign ems_ws = regs_q[O_MEMCFG][3:2];
  assign rom_ws = regs_q[O_MEMCFG][1:0];
  assign ems_io_base = 16'h0208 + {8'h00, regs_q[O_MAPBASE][3:0], 4'h0};
  assign ems_frame_base = 20'hC0000 + {2'b00, regs_q[O_MAPBASE][7:4], 14'h0000};
  assign ems_size_kb = (size_code == 3'd0) ? 13'd512 : {size_code, 10'd0};
  assign ems_pages = ems_size_kb[12:4];

  for (genvar p = 0; p < 4; p++) begin : g_page
    assign ems_page_ext[2*p +: 2] = regs_q[O_PGEXT][6-2*p +: 2];
    assign ems_page_start[24*p +: 24] = {1'b0, ems_page_ext[2*p +: 2], 21'd0};
  end
endmodule

// File: rtl/cfg_idx_port_chk.sv
module cfg_idx_port_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h23,
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        idx_q,
  input logic [8*NREG-1:0] cfg_flat,
  input logic              cfg_update,
  input logic [12:0]       ems_size_kb,
  input logic [8:0]        ems_pages
);
  logic dwr;
  assign dwr = io_wr && io_addr == DAT_PORT;

  AST_REV_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flat[7:6] == 2'b10 && cfg_flat[38:37] == 2'b10); // R4
  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && (idx_q < 8'h60 || idx_q > 8'h6F)) |=> $stable(cfg_flat)); // R9
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == 8'h62) |=> cfg_flat[23:22] == $past(cfg_flat[23:22])); // R3
  AST_UPDATE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == 8'h6F) |=> cfg_update); // R10
  AST_UPDATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> !cfg_update); // R10
  AST_PAGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    {ems_pages, 4'b0000} == ems_size_kb); // R6
endmodule

bind cfg_idx_port cfg_idx_port_chk #(.ADDR_W(ADDR_W), .DAT_PORT(DAT_PORT), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .idx_q(idx_q),
  .cfg_flat(cfg_flat), .cfg_update(cfg_update), .ems_size_kb(ems_size_kb),
  .ems_pages(ems_pages)
);

// File: tb/sim_cfg_idx_port.sv
module sim_cfg_idx_port;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, io_wr, io_rd;
  logic [15:0] io_addr;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;
  logic [127:0] cfg_flat;
  logic ems_en, uma_reloc, cfg_update;
  logic [1:0] ems_ws, rom_ws;
  logic [15:0] ems_io_base;
  logic [19:0] ems_frame_base;
  logic [7:0] ems_page_ext;
  logic [95:0] ems_page_start;
  logic [12:0] ems_size_kb;
  logic [8:0] ems_pages;

  cfg_idx_port u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_flat(cfg_flat), .ems_en(ems_en),
    .uma_reloc(uma_reloc), .ems_ws(ems_ws), .rom_ws(rom_ws), .ems_io_base(ems_io_base),
    .ems_frame_base(ems_frame_base), .ems_page_ext(ems_page_ext),
    .ems_page_start(ems_page_start), .ems_size_kb(ems_size_kb), .ems_pages(ems_pages),
    .cfg_update(cfg_update)
  );

  int checks = 0, errors = 0;
  logic [7:0] mdl [16];
  logic [7:0] midx;

  function automatic logic [7:0] msk(int i);
    case (i)
      0: return 8'h34;
      2: return 8'h3F;
      3, 4: return 8'h00;
      6: return 8'h80;
      10: return 8'hE0;
      12: return 8'hF0;
      15: return 8'hE6;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] fx(int i);
    return (i == 0) ? 8'h80 : (i == 4) ? 8'h40 : 8'h00;
  endfunction

  function automatic bit inwin(logic [7:0] ix);
    return ix >= 8'h60 && ix <= 8'h6F;
  endfunction

  function automatic logic [127:0] mflat();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[8*i +: 8] = mdl[i];
    return f;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [15:0] a, logic [7:0] d);
    bit pulse;
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    pulse = (a == 16'h23) && (midx == 8'h6B || midx == 8'h6D || midx == 8'h6E || midx == 8'h6F);
    if (a == 16'h22) midx = d;
    else if (a == 16'h23 && inwin(midx))
      mdl[midx - 8'h60] = (mdl[midx - 8'h60] & ~msk(midx - 8'h60)) |
                          (d & msk(midx - 8'h60)) | fx(midx - 8'h60);
    @(negedge clk);
    chk("R10 update strobe", 128'(cfg_update), 128'(pulse));
    io_wr = 1'b0;
  endtask

  task automatic do_rd(logic [15:0] a, logic [7:0] exp, string req);
    io_addr = a; io_rd = 1'b1;
    #1;
    chk(req, 128'(io_rdata), 128'(exp));
    io_rd = 1'b0;
  endtask

  task automatic chk_derived();
    logic [2:0] c;
    logic [12:0] kb;
    logic [95:0] st;
    logic [7:0] ex;
    c = mdl[15][7:5];
    kb = (c == 0) ? 13'd512 : 13'(c) * 13'd1024;
    for (int p = 0; p < 4; p++) begin
      ex[2*p +: 2] = mdl[14][7-2*p -: 2];
      st[24*p +: 24] = 24'(ex[2*p +: 2]) * 24'h200000;
    end
    chk("R3 R4 flat registers", cfg_flat, mflat());
    chk("R5 mapper fields", {ems_en, uma_reloc, ems_ws, rom_ws},
        {mdl[11][4], mdl[11][6], mdl[11][3:2], mdl[11][1:0]});
    chk("R6 size", 128'(ems_size_kb), 128'(kb));
    chk("R6 pages", 128'(ems_pages), 128'(kb / 16));
    chk("R7 io base", 128'(ems_io_base), 128'(16'h208 + 16'h10 * mdl[13][3:0]));
    chk("R7 frame", 128'(ems_frame_base), 128'(20'hC0000 + 20'h4000 * mdl[13][7:4]));
    chk("R8 page ext", 128'(ems_page_ext), 128'(ex));
    chk("R8 page start", 128'(ems_page_start), 128'(st));
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0; rst_n = 0; midx = 0;
    for (int i = 0; i < 16; i++) mdl[i] = fx(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    do_rd(16'h22, 8'h00, "R11 R1 pointer reset");
    chk("R11 reset flat", cfg_flat, mflat());
    chk_derived();
    for (int i = 0; i < 16; i++) begin
      do_wr(16'h22, 8'(8'h60 + i));
      do_rd(16'h23, fx(i), "R11 R2 reset read");
    end
    do_rd(16'h22, 8'h6F, "R1 pointer readback");

    do_wr(16'h22, 8'h60); do_wr(16'h23, 8'hFF);
    do_rd(16'h23, 8'hB4, "R4 R3 reg 0x60 all ones");
    do_wr(16'h22, 8'h64); do_wr(16'h23, 8'hFF);
    do_rd(16'h23, 8'h40, "R4 reg 0x64 all ones");
    do_wr(16'h22, 8'h6F); do_wr(16'h23, 8'h00); chk_derived();
    do_wr(16'h23, 8'h20); chk_derived();
    do_wr(16'h23, 8'hE0); chk_derived();
    do_wr(16'h22, 8'h6D); do_wr(16'h23, 8'hFF); chk_derived();
    do_wr(16'h22, 8'h6E); do_wr(16'h23, 8'h1B); chk_derived();

    do_wr(16'h22, 8'h5F); do_wr(16'h23, 8'hAA);
    do_rd(16'h23, 8'hFF, "R9 read below window");
    chk("R9 below window write ignored", cfg_flat, mflat());
    do_wr(16'h22, 8'h70); do_wr(16'h23, 8'h55);
    do_rd(16'h23, 8'hFF, "R9 read above window");
    chk("R9 above window write ignored", cfg_flat, mflat());
    do_wr(16'h24, 8'h99);
    chk("R2 other address write ignored", cfg_flat, mflat());
    do_rd(16'h22, 8'h70, "R2 pointer untouched by other address");
    do_rd(16'h30, 8'hFF, "R2 other address read");
    io_addr = 16'h22; #1;
    chk("R2 no strobe read", 128'(io_rdata), 128'hFF);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] ix;
      ix = 8'($urandom_range(8'h5C, 8'h73));
      do_wr(16'h22, ix);
      do_wr(16'h23, 8'($urandom));
      do_rd(16'h23, inwin(ix) ? mdl[ix - 8'h60] : 8'hFF, "R2 R3 R9 random readback");
      chk_derived();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule